// File: doc/BRIEF.md
# Target Selection Response Detector

This block sits on the target side of a shared parallel peripheral bus. It decides whether to answer when an initiator tries to select it. It watches the eight data lines, their parity line, and the busy, select, direction (I/O) and attention control lines. It compares what it sees against a configured own-ID. When the bus carries a valid selection aimed at this device, it drives its busy output to claim the connection. It also reports which initiator selected it and whether that initiator asked for a message-out phase.

An invalid selection gets no answer at all. Bad parity, the wrong number of ID bits, a missing own-ID bit, or the reselection direction all count as invalid. The initiator is left to detect the missing response as a timeout. Inputs are acted on only after they have held steady for a programmable deskew count.

Once connected, busy stays asserted until the phase sequencer that follows pulses a disconnect. After that, the select line must be seen released before another selection can be accepted.

Top module: `sel_resp_detect`

## Requirements
- R1: After reset, `bsy_out`, `selected` and `atn_pending` are 0.
- R2: A valid selection asserts `bsy_out`, and `selected` is high for exactly one cycle. A selection is valid when all of the following hold: `sel_in`=1, `bsy_in`=0, `io_in`=0, odd parity, exactly two data bits set, and bit `own_id` among them. `init_id` then holds the index of the other set bit.
- R3: Parity is odd over the data lines and `bus_par` together. If the total count of ones is even, `bsy_out` stays 0.
- R4: If the number of set data bits is anything other than two, `bsy_out` stays 0. This includes more than two.
- R5: If bit `own_id` of the data lines is clear, `bsy_out` stays 0.
- R6: With `io_in`=1 the pattern is a reselection and does not apply to a target, so `bsy_out` stays 0.
- R7: If `bsy_in` is asserted while select is seen, `bsy_out` stays 0.
- R8: `atn_pending` takes the value of `atn_in` as seen in the accepted selection, and it is cleared on disconnect.
- R9: The inputs pass through one register stage. A selection is acted on only after the registered inputs have matched for DESKEW consecutive compares. With inputs changed just before clock edge k, `bsy_out` rises after edge k+DESKEW+2 and not earlier. A change during the window restarts it.
- R10: A `disconnect` pulse while connected drops `bsy_out` on the next edge. No new selection is accepted until `sel_in`=0 has been seen stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_id | input | 3 | This device's ID, as a bit index on the data lines |
| bus_data | input | 8 | Data lines carrying the ID bits |
| bus_par | input | 1 | Data parity line |
| bsy_in | input | 1 | Busy line as seen on the bus |
| sel_in | input | 1 | Select line |
| io_in | input | 1 | Direction line; 1 marks a reselection |
| atn_in | input | 1 | Attention line |
| disconnect | input | 1 | Pulse from the phase sequencer that releases the connection |
| bsy_out | output | 1 | Busy drive for the bus |
| selected | output | 1 | One-cycle strobe when a selection is accepted |
| atn_pending | output | 1 | A message-out phase is expected |
| init_id | output | 3 | ID of the selecting initiator |

## Verification
The assertions assume that `own_id` is held constant while the block is out of reset. They also assume `disconnect` is pulsed only after the stimulus has seen `bsy_out` high.

The stimulus changes bus inputs only on the falling edge and holds each pattern long past the deskew window. Each random trial begins from an idle bus, with select released, and releases any connection it made before the next trial starts. Directed cases add three more situations:
- a pattern that changes in the middle of the deskew window;
- a disconnect issued while select is still held;
- the exact cycle in which busy first rises.

// File: rtl/sel_resp_pkg.sv
package sel_resp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONN  = 2'd1,
    ST_REARM = 2'd2
  } conn_state_e;
endpackage

// File: rtl/srd_sampler.sv
module srd_sampler #(
  parameter int VEC_W  = 13,
  parameter int DESKEW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VEC_W-1:0] raw,
  output logic [VEC_W-1:0] smp,
  output logic             stable
);
  localparam int CNT_W = $clog2(DESKEW + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DESKEW);

  logic [VEC_W-1:0] prev;
  logic [CNT_W-1:0] cnt;
  logic             same;

  assign same   = (smp == prev);
  assign stable = same && (cnt == CNT_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp  <= '0;
      prev <= '0;
      cnt  <= '0;
    end else begin
      smp  <= raw;
      prev <= smp;
      if (!same)
        cnt <= '0;
      else if (cnt != CNT_TOP)
        cnt <= cnt + 1'b1;
    end
  end

  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_TOP);
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !same |=> (cnt == '0));
endmodule

// File: rtl/srd_check.sv
module srd_check #(
  parameter int DATA_W = 8,
  parameter int ID_W   = 3
) (
  input  logic [DATA_W-1:0] data,
  input  logic              par,
  input  logic              bsy,
  input  logic              sel,
  input  logic              io,
  input  logic [ID_W-1:0]   own_id,
  output logic              par_ok,
  output logic              cnt_ok,
  output logic              own_hit,
  output logic              sel_valid,
  output logic [ID_W-1:0]   peer_id
);
  localparam int POP_W = $clog2(DATA_W + 1);

  function automatic logic odd_ok(input logic [DATA_W-1:0] d, input logic p);
    return ^{d, p};
  endfunction

  function automatic logic [POP_W-1:0] ones(input logic [DATA_W-1:0] d);
    logic [POP_W-1:0] n;
    n = '0;
    for (int i = 0; i < DATA_W; i++) n = n + POP_W'(d[i]);
    return n;
  endfunction

  function automatic logic [ID_W-1:0] other_bit(input logic [DATA_W-1:0] d,
                                                input logic [ID_W-1:0] me);
    logic [ID_W-1:0] r;
    r = '0;
    for (int i = 0; i < DATA_W; i++)
      if (d[i] && (ID_W'(i) != me)) r = ID_W'(i);
    return r;
  endfunction

  assign par_ok    = odd_ok(data, par);
  assign cnt_ok    = (ones(data) == POP_W'(2));
  assign own_hit   = data[own_id];
  assign sel_valid = sel && !bsy && !io && par_ok && cnt_ok && own_hit;
  assign peer_id   = other_bit(data, own_id);
endmodule

// File: rtl/srd_ctrl.sv
module srd_ctrl
  import sel_resp_pkg::*;
#(
  parameter int ID_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stable,
  input  logic            sel_valid,
  input  logic            sel_low,
  input  logic            atn_s,
  input  logic [ID_W-1:0] peer_id,
  input  logic            disconnect,
  output logic            bsy_out,
  output logic            selected,
  output logic            atn_pending,
  output logic [ID_W-1:0] init_id,
  output conn_state_e     state
);
  logic accept_ev;
  logic release_ev;

  assign accept_ev  = (state == ST_IDLE) && stable && sel_valid;
  assign release_ev = (state == ST_CONN) && disconnect;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      bsy_out     <= 1'b0;
      selected    <= 1'b0;
      atn_pending <= 1'b0;
      init_id     <= '0;
    end else begin
      selected <= accept_ev;
      unique case (state)
        ST_IDLE: if (accept_ev) begin
          state       <= ST_CONN;
          bsy_out     <= 1'b1;
          atn_pending <= atn_s;
          init_id     <= peer_id;
        end
        ST_CONN: if (release_ev) begin
          state       <= ST_REARM;
          bsy_out     <= 1'b0;
          atn_pending <= 1'b0;
        end
        ST_REARM: if (stable && sel_low) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    selected |=> !selected);
  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    release_ev |=> !bsy_out && !atn_pending);
  p_atn_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bsy_out |-> !atn_pending);
endmodule

// File: rtl/sel_resp_detect.sv
module sel_resp_detect
  import sel_resp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DESKEW = 3,
  parameter int ID_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   own_id,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_par,
  input  logic              bsy_in,
  input  logic              sel_in,
  input  logic              io_in,
  input  logic              atn_in,
  input  logic              disconnect,
  output logic              bsy_out,
  output logic              selected,
  output logic              atn_pending,
  output logic [ID_W-1:0]   init_id
);
  localparam int VEC_W = DATA_W + 5;

  logic [VEC_W-1:0]  raw_vec;
  logic [VEC_W-1:0]  smp_vec;
  logic              stable;
  logic [DATA_W-1:0] s_data;
  logic              s_par, s_bsy, s_sel, s_io, s_atn;
  logic              par_ok, cnt_ok, own_hit, sel_valid;
  logic [ID_W-1:0]   peer_id;
  conn_state_e       state;

  assign raw_vec = {bus_data, bus_par, bsy_in, sel_in, io_in, atn_in};
  assign {s_data, s_par, s_bsy, s_sel, s_io, s_atn} = smp_vec;

  srd_sampler #(.VEC_W(VEC_W), .DESKEW(DESKEW)) u_smp (
    .clk(clk), .rst_n(rst_n), .raw(raw_vec), .smp(smp_vec), .stable(stable)
  );

  srd_check #(.DATA_W(DATA_W), .ID_W(ID_W)) u_chk (
    .data(s_data), .par(s_par), .bsy(s_bsy), .sel(s_sel), .io(s_io),
    .own_id(own_id), .par_ok(par_ok), .cnt_ok(cnt_ok), .own_hit(own_hit),
    .sel_valid(sel_valid), .peer_id(peer_id)
  );

  srd_ctrl #(.ID_W(ID_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .stable(stable), .sel_valid(sel_valid),
    .sel_low(!s_sel), .atn_s(s_atn), .peer_id(peer_id),
    .disconnect(disconnect), .bsy_out(bsy_out), .selected(selected),
    .atn_pending(atn_pending), .init_id(init_id), .state(state)
  );

  p_rise_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bsy_out) |-> $past(sel_valid) && selected);
  p_parity_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bsy_out) |-> $past(par_ok));
  p_idcount_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bsy_out) |-> $past(cnt_ok && own_hit));
  p_dir_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bsy_out) |-> $past(!s_io && !s_bsy));
  p_atn_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bsy_out) |-> (atn_pending == $past(s_atn)));
  p_deskew_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bsy_out) |-> $past(stable));
  p_fall_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bsy_out) |-> $past(disconnect));
endmodule

// File: tb/sel_resp_detect_tb.sv
module sel_resp_detect_tb;
  localparam int DESKEW = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] own_id = 3'd5;
  logic [7:0] bus_data = '0;
  logic       bus_par = 1'b1;
  logic       bsy_in = 1'b0, sel_in = 1'b0, io_in = 1'b0, atn_in = 1'b0;
  logic       disconnect = 1'b0;
  logic       bsy_out, selected, atn_pending;
  logic [2:0] init_id;

  int n_cmp = 0;
  int n_bad = 0;
  int strobes = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sel_resp_detect #(.DATA_W(8), .DESKEW(DESKEW)) u_dut (
    .clk(clk), .rst_n(rst_n), .own_id(own_id), .bus_data(bus_data),
    .bus_par(bus_par), .bsy_in(bsy_in), .sel_in(sel_in), .io_in(io_in),
    .atn_in(atn_in), .disconnect(disconnect), .bsy_out(bsy_out),
    .selected(selected), .atn_pending(atn_pending), .init_id(init_id)
  );

  always @(posedge clk) if (selected) strobes <= strobes + 1;

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit good_par(input logic [7:0] d, input logic p);
    int k = 0;
    for (int i = 0; i < 8; i++) k += d[i];
    k += p;
    return (k % 2) == 1;
  endfunction

  function automatic bit expect_resp(input logic [7:0] d, input logic p,
      input logic b, input logic s, input logic io, input logic [2:0] me);
    int k = 0;
    for (int i = 0; i < 8; i++) k += d[i];
    return s && !b && !io && good_par(d, p) && (k == 2) && d[me];
  endfunction

  function automatic int peer_of(input logic [7:0] d, input logic [2:0] me);
    for (int i = 0; i < 8; i++) if (d[i] && i != me) return i;
    return 0;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic [7:0] d, input logic p, input logic b,
                       input logic s, input logic io, input logic a);
    bus_data = d; bus_par = p; bsy_in = b; sel_in = s; io_in = io; atn_in = a;
  endtask

  task automatic idle_bus();
    drive(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(DESKEW + 4);
  endtask

  task automatic release_link();
    disconnect = 1'b1;
    cyc(1);
    disconnect = 1'b0;
    check("R10 bsy released", bsy_out, 0);
    check("R8 atn cleared", atn_pending, 0);
    idle_bus();
  endtask

  task automatic trial(input logic [7:0] d, input logic p, input logic b,
                       input logic io, input logic a, input string tag);
    int s0;
    bit e;
    e = expect_resp(d, p, b, 1'b1, io, own_id);
    s0 = strobes;
    drive(d, p, b, 1'b1, io, a);
    cyc(DESKEW + 6);
    check({tag, " bsy"}, bsy_out, e);
    check({tag, " strobe count R2"}, strobes - s0, e);
    if (e) begin
      check({tag, " init_id R2"}, init_id, peer_of(d, own_id));
      check({tag, " atn R8"}, atn_pending, a);
      release_link();
    end else begin
      idle_bus();
    end
  endtask

  function automatic logic [7:0] pair_with(input logic [2:0] me, input int o);
    logic [7:0] v;
    v = 8'h00;
    v[me] = 1'b1;
    v[o] = 1'b1;
    return v;
  endfunction

  initial begin
    int dummy;
    dummy = $urandom(32'd20240611);
    cyc(2);
    check("R1 bsy reset", bsy_out, 0);
    check("R1 selected reset", selected, 0);
    check("R1 atn reset", atn_pending, 0);
    rst_n = 1'b1;
    idle_bus();

    // directed: R2 valid, R3 bad parity, R4 three bits, R5 no own bit,
    // R6 reselection direction, R7 busy already asserted
    trial(pair_with(own_id, 2), 1'b1, 1'b0, 1'b0, 1'b1, "R2");
    trial(pair_with(own_id, 2), 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    trial(pair_with(own_id, 2) | 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
    trial(8'h00 | (8'h01 << own_id), 1'b0, 1'b0, 1'b0, 1'b0, "R4 single");
    trial(8'h41 & ~(8'h01 << own_id), 1'b1, 1'b0, 1'b0, 1'b0, "R5");
    trial(pair_with(own_id, 7), 1'b1, 1'b0, 1'b1, 1'b0, "R6");
    trial(pair_with(own_id, 0), 1'b1, 1'b1, 1'b0, 1'b0, "R7");

    // R9: exact rise cycle, and restart on a change within the window
    drive(pair_with(own_id, 3), 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    cyc(DESKEW + 2);
    check("R9 not before window", bsy_out, 0);
    cyc(1);
    check("R9 rises on time", bsy_out, 1);
    release_link();
    drive(pair_with(own_id, 3), 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    cyc(DESKEW);
    atn_in = 1'b1;
    cyc(DESKEW + 2);
    check("R9 restart holds off", bsy_out, 0);
    cyc(1);
    check("R9 restart then rises", bsy_out, 1);
    check("R8 atn after restart", atn_pending, 1);

    // R10: disconnect with select still held, no re-accept until released
    disconnect = 1'b1;
    cyc(1);
    disconnect = 1'b0;
    cyc(DESKEW + 6);
    check("R10 no re-accept while sel held", bsy_out, 0);
    idle_bus();
    trial(pair_with(own_id, 1), 1'b1, 1'b0, 1'b0, 1'b0, "R10 re-accept");

    // constrained random
    for (int t = 0; t < 120; t++) begin
      logic [7:0] d;
      logic p;
      int mode;
      own_id = 3'($urandom % 8);
      idle_bus();
      mode = $urandom % 6;
      d = pair_with(own_id, (own_id + 1 + $urandom % 7) % 8);
      if (mode == 1) d = d | 8'(1 << ($urandom % 8));
      if (mode == 3) d = 8'($urandom);
      p = ~(^d);
      if (mode == 2) p = ~p;
      trial(d, p, mode == 5, mode == 4, 1'($urandom), "rand R2-set");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule